// File: doc/BRIEF.md
# Sensor Power Mode Sequencer

This block steps an image sensor through its five operating modes: standby, sleep, clock-active, idle and streaming. Standby is forced by an active-low power-down pin, which passes through a short synchronizer. The four awake modes are reached one at a time through mode commands from the control register interface. Each awake mode switches on one more domain than the mode below it: the control interface, then the PLL and output clock driver, then the analog video section, and last the data output drivers. The pixel array is released from reset only in the last step.

A request to return to sleep while frames are streaming takes effect at the next frame-boundary strobe from the video timing logic. The frame in progress is therefore never cut short. Every entry into sleep by command also sends a one-cycle pulse that moves the video timing back to the start of a frame. A command that would skip a step is refused and sets a sticky error flag. Leaving standby always lands in sleep and sends a one-cycle pulse that reloads the configuration defaults. A retention flag shows whether configuration contents are being kept.

Top module: `sensor_pwr_seq`

## Requirements
- R1: While the synchronized power-down pin is low, `standby` is 1, `mode_status` reads 0, and `en_ctrl`, `en_pll`, `en_ana` and `en_dout` are all 0. `array_rst` and `dout_inhibit` are 1. Standby takes effect on the third rising clock edge after the pin falls.
- R2: On the third rising edge after the pin rises, the block leaves standby and enters sleep (`mode_status` = 0). `cfg_load` is 1 for exactly that one cycle, and `cmd_err` is 0.
- R3: The domain enables depend on the awake mode, with `mode_status` coded as 0 sleep, 1 clock-active, 2 idle and 3 streaming. Sleep has only `en_ctrl`. Clock-active adds `en_pll`. Idle adds `en_ana` and keeps `array_rst` = 1 and `dout_inhibit` = 1. Streaming adds `en_dout`, with `array_rst` = 0 and `dout_inhibit` = 0.
- R4: A command (`cmd_we` = 1, `cmd_mode` uses the same code as R3) whose target is exactly one mode above the current mode takes effect on the next clock edge.
- R5: A non-sleep command whose target is neither the current mode nor the next mode up leaves the mode unchanged and sets `cmd_err`.
- R6: Once `cmd_err` is set, it stays set until the block enters standby.
- R7: A sleep command issued while streaming, with no frame strobe in the same cycle, keeps streaming with every output unchanged. A frame strobe alone in streaming does nothing. The first `frame_end` after a deferred sleep request moves the block to sleep on the next edge.
- R8: A sleep command issued while streaming in the same cycle as `frame_end` enters sleep on that edge.
- R9: Each entry into sleep by command raises `vid_tmg_rst` for exactly one cycle, the first cycle spent in sleep.
- R10: While in standby, commands and frame strobes are ignored, and release still lands in sleep.
- R11: `cfg_kept` is 0 in standby and 1 in every awake mode.
- R12: While a deferred sleep is pending, a non-sleep command sets `cmd_err` and leaves the mode at streaming.
- R13: A sleep command from clock-active or idle enters sleep on the next edge.
- R14: If the power-down pin falls while a deferred sleep is pending, the block enters standby without waiting for a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; puts the block in standby |
| pwrdn_n | input | 1 | Asynchronous active-low power-down pin |
| cmd_we | input | 1 | Mode command strobe |
| cmd_mode | input | 2 | Requested mode (0 sleep, 1 clock-active, 2 idle, 3 streaming) |
| frame_end | input | 1 | One-cycle frame-boundary strobe from video timing |
| en_ctrl | output | 1 | Control interface enable |
| en_pll | output | 1 | PLL and output clock driver enable |
| en_ana | output | 1 | Analog video section enable |
| array_rst | output | 1 | Pixel array held in reset |
| en_dout | output | 1 | Data output driver enable |
| dout_inhibit | output | 1 | Data outputs forced high |
| vid_tmg_rst | output | 1 | One-cycle pulse that restarts video timing at frame start |
| cfg_load | output | 1 | One-cycle pulse that reloads configuration defaults |
| cfg_kept | output | 1 | Configuration contents are retained |
| mode_status | output | 2 | Current awake mode, same code as `cmd_mode` |
| standby | output | 1 | Block is in standby |
| cmd_err | output | 1 | Sticky flag for a refused command |

## Verification
Two events can meet in one cycle: a sleep command from streaming and a frame-boundary strobe. The bench drives both in the same clock cycle. It expects sleep and the timing-restart pulse one edge later, with no pending wait. A second collision is a power-down while a deferred sleep is still waiting. The bench expects standby to win on the third edge with no strobe. A further case is a non-sleep command that arrives while the deferral is open. The bench judges this by the error flag and by the mode still reading streaming.

// File: rtl/sensor_pwr_seq.sv
module sensor_pwr_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdn_n,
  input  logic       cmd_we,
  input  logic [1:0] cmd_mode,
  input  logic       frame_end,
  output logic       en_ctrl,
  output logic       en_pll,
  output logic       en_ana,
  output logic       array_rst,
  output logic       en_dout,
  output logic       dout_inhibit,
  output logic       vid_tmg_rst,
  output logic       cfg_load,
  output logic       cfg_kept,
  output logic [1:0] mode_status,
  output logic       standby,
  output logic       cmd_err
);
  localparam int MODE_W = 2;
  localparam logic [MODE_W-1:0] M_SLEEP  = 2'd0;
  localparam logic [MODE_W-1:0] M_CLKACT = 2'd1;
  localparam logic [MODE_W-1:0] M_IDLE   = 2'd2;
  localparam logic [MODE_W-1:0] M_STREAM = 2'd3;

  logic [SYNC_STAGES-1:0] pd_sh;
  logic [MODE_W-1:0]      mode_q;
  logic                   stby_q, pend_q, err_q, tmrst_q, load_q;

  wire pd_ok     = pd_sh[SYNC_STAGES-1];
  wire sleep_req = cmd_we && (cmd_mode == M_SLEEP);
  wire in_stream = (mode_q == M_STREAM);
  wire next_up   = (cmd_mode == MODE_W'(mode_q + 1'b1));
  wire go_sleep  = (pend_q && frame_end)
                || (sleep_req && in_stream && frame_end)
                || (sleep_req && !in_stream && mode_q != M_SLEEP);
  wire defer     = sleep_req && in_stream && !frame_end;
  wire go_up     = cmd_we && !sleep_req && !pend_q && next_up;
  wire bad_cmd   = cmd_we && !sleep_req && (pend_q || (cmd_mode != mode_q && !next_up));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_sh   <= '0;
      stby_q  <= 1'b1;
      mode_q  <= M_SLEEP;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      tmrst_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      pd_sh   <= {pd_sh[SYNC_STAGES-2:0], pwrdn_n};
      tmrst_q <= 1'b0;
      load_q  <= 1'b0;
      if (!pd_ok) begin
        stby_q <= 1'b1;
        mode_q <= M_SLEEP;
        pend_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (stby_q) begin
        stby_q <= 1'b0;
        mode_q <= M_SLEEP;
        load_q <= 1'b1;
        err_q  <= 1'b0;
      end else begin
        if (go_sleep) begin
          mode_q  <= M_SLEEP;
          pend_q  <= 1'b0;
          tmrst_q <= 1'b1;
        end else if (go_up) begin
          mode_q <= cmd_mode;
        end else if (defer) begin
          pend_q <= 1'b1;
        end
        if (bad_cmd) err_q <= 1'b1;
      end
    end
  end

  assign en_ctrl      = !stby_q;
  assign en_pll       = !stby_q && (mode_q != M_SLEEP);
  assign en_ana       = !stby_q && (mode_q == M_IDLE || mode_q == M_STREAM);
  assign en_dout      = !stby_q && in_stream;
  assign array_rst    = !en_dout;
  assign dout_inhibit = !en_dout;
  assign vid_tmg_rst  = tmrst_q;
  assign cfg_load     = load_q;
  assign cfg_kept     = !stby_q;
  assign mode_status  = mode_q;
  assign standby      = stby_q;
  assign cmd_err      = err_q;

  wire unused_ok = (M_CLKACT == 2'd1);
  initial if (!unused_ok) $display("mode code mismatch");
endmodule

module sensor_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [1:0] cmd_mode,
  input logic       frame_end,
  input logic       en_ctrl,
  input logic       en_pll,
  input logic       en_ana,
  input logic       array_rst,
  input logic       en_dout,
  input logic       vid_tmg_rst,
  input logic       cfg_kept,
  input logic [1:0] mode_status,
  input logic       standby,
  input logic       cmd_err
);
  assert_stby_all_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!en_ctrl && !en_pll && !en_ana && !en_dout && mode_status == 2'd0));

  assert_domain_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pll |-> en_ctrl) and (en_ana |-> en_pll) and (en_dout |-> (en_ana && !array_rst)));

  assert_single_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && !$past(standby) && mode_status != $past(mode_status))
      |-> (mode_status == 2'($past(mode_status) + 2'd1) || mode_status == 2'd0));

  assert_skip_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !standby && cmd_mode != 2'd0 && cmd_mode != mode_status
      && cmd_mode != 2'(mode_status + 2'd1))
      |=> (cmd_err || standby));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> (cmd_err || standby));

  assert_stream_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_dout && !frame_end) |=> (en_dout || standby));

  assert_tmg_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vid_tmg_rst |-> (mode_status == 2'd0 && !standby) ##1 !vid_tmg_rst);

  assert_kept_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_kept != standby);
endmodule

bind sensor_pwr_seq sensor_pwr_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_mode(cmd_mode),
  .frame_end(frame_end), .en_ctrl(en_ctrl), .en_pll(en_pll), .en_ana(en_ana),
  .array_rst(array_rst), .en_dout(en_dout), .vid_tmg_rst(vid_tmg_rst),
  .cfg_kept(cfg_kept), .mode_status(mode_status), .standby(standby),
  .cmd_err(cmd_err)
);

// File: tb/sensor_pwr_seq_tb_top.sv
module sensor_pwr_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrdn_n = 1'b1;
  logic cmd_we = 1'b0;
  logic [1:0] cmd_mode = 2'd0;
  logic frame_end = 1'b0;
  logic en_ctrl, en_pll, en_ana, array_rst, en_dout, dout_inhibit;
  logic vid_tmg_rst, cfg_load, cfg_kept, standby, cmd_err;
  logic [1:0] mode_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sensor_pwr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .cmd_we(cmd_we),
    .cmd_mode(cmd_mode), .frame_end(frame_end), .en_ctrl(en_ctrl),
    .en_pll(en_pll), .en_ana(en_ana), .array_rst(array_rst),
    .en_dout(en_dout), .dout_inhibit(dout_inhibit), .vid_tmg_rst(vid_tmg_rst),
    .cfg_load(cfg_load), .cfg_kept(cfg_kept), .mode_status(mode_status),
    .standby(standby), .cmd_err(cmd_err)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_mode(string tag, int stb, int md);
    int dom;
    dom = (md >= 1) + (md >= 2) + (md >= 3);
    chk({tag, " standby"}, standby, stb);
    chk({tag, " mode"}, mode_status, md);
    chk({tag, " en_ctrl"}, en_ctrl, !stb);
    chk({tag, " en_pll"}, en_pll, !stb && dom >= 1);
    chk({tag, " en_ana"}, en_ana, !stb && dom >= 2);
    chk({tag, " en_dout"}, en_dout, !stb && dom >= 3);
    chk({tag, " array_rst"}, array_rst, !(!stb && dom >= 3));
    chk({tag, " dout_inhibit"}, dout_inhibit, !(!stb && dom >= 3));
    chk({tag, " cfg_kept"}, cfg_kept, !stb);
  endtask

  task automatic send(logic [1:0] m, bit fe);
    @(negedge clk);
    cmd_we = 1'b1; cmd_mode = m; frame_end = fe;
    @(negedge clk);
    cmd_we = 1'b0; frame_end = 1'b0;
  endtask

  task automatic enter_standby(string tag);
    @(negedge clk);
    pwrdn_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({tag, " R1 not yet standby"}, standby, 0);
    @(negedge clk);
    chk_mode({tag, " R1"}, 1, 0);
    chk({tag, " R6 err cleared"}, cmd_err, 0);
  endtask

  task automatic release_pd(string tag);
    @(negedge clk);
    pwrdn_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_mode({tag, " R2 R11"}, 0, 0);
    chk({tag, " R2 cfg_load"}, cfg_load, 1);
    chk({tag, " R2 cmd_err"}, cmd_err, 0);
    @(negedge clk);
    chk({tag, " R2 cfg_load one cycle"}, cfg_load, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk_mode("reset R1", 1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_mode("reset exit R2", 0, 0);
    chk("reset exit R2 cfg_load", cfg_load, 1);
    @(negedge clk);
    chk("reset exit R2 load pulse", cfg_load, 0);
  endtask

  task automatic t_bringup;
    send(2'd1, 1'b0); chk_mode("up R4 R3 clkact", 0, 1);
    send(2'd2, 1'b0); chk_mode("up R4 R3 idle", 0, 2);
    send(2'd3, 1'b0); chk_mode("up R4 R3 stream", 0, 3);
    chk("up R4 no err", cmd_err, 0);
  endtask

  task automatic t_skip;
    send(2'd3, 1'b0);
    chk_mode("skip R5", 0, 0);
    chk("skip R5 err", cmd_err, 1);
    send(2'd1, 1'b0);
    chk_mode("sticky R6 legal step", 0, 1);
    chk("sticky R6 err", cmd_err, 1);
    send(2'd0, 1'b0);
    chk("sticky R6 after sleep", cmd_err, 1);
    enter_standby("sticky R6 standby");
    release_pd("sticky R6 release");
  endtask

  task automatic t_standby_ignore;
    enter_standby("ignore R10");
    send(2'd1, 1'b1);
    chk_mode("ignore R10 cmd", 1, 0);
    chk("ignore R10 no tmg pulse", vid_tmg_rst, 0);
    release_pd("ignore R10 release");
  endtask

  task automatic t_defer;
    t_bringup();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    chk_mode("defer R7 lone strobe", 0, 3);
    send(2'd0, 1'b0);
    chk_mode("defer R7 pending", 0, 3);
    repeat (2) @(negedge clk);
    chk_mode("defer R7 still streaming", 0, 3);
    chk("defer R9 no pulse yet", vid_tmg_rst, 0);
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    chk_mode("defer R7 at frame end", 0, 0);
    chk("defer R9 pulse", vid_tmg_rst, 1);
    @(negedge clk);
    chk("defer R9 pulse width", vid_tmg_rst, 0);
  endtask

  task automatic t_coincide;
    t_bringup();
    send(2'd0, 1'b1);
    chk_mode("coincide R8", 0, 0);
    chk("coincide R8 R9 pulse", vid_tmg_rst, 1);
    @(negedge clk);
    chk("coincide R9 pulse width", vid_tmg_rst, 0);
    chk_mode("coincide R8 stays", 0, 0);
  endtask

  task automatic t_low_sleep;
    send(2'd1, 1'b0); send(2'd2, 1'b0);
    send(2'd0, 1'b0);
    chk_mode("low R13 idle to sleep", 0, 0);
    chk("low R13 R9 pulse", vid_tmg_rst, 1);
    send(2'd1, 1'b0);
    send(2'd0, 1'b0);
    chk_mode("low R13 clkact to sleep", 0, 0);
    send(2'd0, 1'b0);
    chk("low R9 sleep in sleep no pulse", vid_tmg_rst, 0);
    chk("low R13 no err", cmd_err, 0);
  endtask

  task automatic t_pending_cmd;
    t_bringup();
    send(2'd0, 1'b0);
    send(2'd2, 1'b0);
    chk_mode("pend R12 mode", 0, 3);
    chk("pend R12 err", cmd_err, 1);
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    chk_mode("pend R12 then frame end", 0, 0);
    chk("pend R6 err kept", cmd_err, 1);
  endtask

  task automatic t_pd_pending;
    enter_standby("pdpend clear");
    release_pd("pdpend clear");
    t_bringup();
    send(2'd0, 1'b0);
    chk_mode("pdpend R14 pending", 0, 3);
    enter_standby("pdpend R14");
    release_pd("pdpend R14");
    repeat (2) @(negedge clk);
    chk("pdpend R9 no stray pulse", vid_tmg_rst, 0);
  endtask

  initial begin
    t_reset();
    t_skip();
    t_standby_ignore();
    t_defer();
    t_coincide();
    t_low_sleep();
    t_pending_cmd();
    t_pd_pending();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule